// File: doc/BRIEF.md
# Interrupt Request Routing Mapper

This block takes a wide set of discrete interrupt request lines from on-chip peripherals and steers each one, under register control, onto one of the fifteen usable inputs of a pair of cascaded legacy interrupt controllers, or onto a single system-management interrupt line. Every source has its own mask bit. Software can read the raw level of every source and the masked pending view, both packed 32 sources to a word.

Each source owns a 5-bit routing code. Code 0 leaves the source unconnected. Codes 1 through 15 pick a legacy controller input. Line 2 carries the cascade between the two controllers and is never driven, so code 2 is redirected to line 0. Code 16 picks the management output. Codes 17 through 31 are reserved and route nowhere. Each output is the OR of every unmasked source routed to it, captured in a register once per clock. Configuration and status use a simple synchronous register bus: writes take effect at the clock edge, and reads return data one cycle after the request.

Top module: `irq_route_mapper`

## Requirements
- R1: After reset every source is masked (mask words read 0xFFFFFFFF and 0x3FFFFFFF), every routing code reads 0, all legacy lines and the management line are low, and read data is 0.
- R2: Routing codes sit in word addresses 0x00 to 0x0F, four per word. Source s uses word s/4, bits [8*(s%4)+4 : 8*(s%4)]. A written code reads back unchanged, and the other bits of the word read 0.
- R3: An unmasked, active source with code c from 1 to 15 drives legacy line c, except code 2, which drives line 0. Legacy line 2 (the cascade) never goes high.
- R4: Code 16 drives the management output and no legacy line. Code 0 and codes 17 to 31 drive no output.
- R5: Mask bits sit at address 0x10 (sources 0 to 31, bit s) and 0x11 (sources 32 to 61, bit s-32). 1 means masked. A masked source drives no output.
- R6: Each output is the OR of all unmasked active sources routed to it. It changes at the first clock edge after the sources change.
- R7: Raw source levels read at 0x12/0x13, and pending (raw AND NOT mask) at 0x14/0x15, with the same bit layout as the mask words.
- R8: Read data appears one cycle after a read request and holds when no read is requested. Unused bits and unmapped addresses read 0.
- R9: Writes to the status addresses 0x12 to 0x15 change no mask bit and no routing code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 62 | Interrupt request levels from the sources |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the read request |
| irq_line_o | output | 16 | Legacy controller inputs, indexed by line number (bit 2 is the cascade and stays low) |
| smi_o | output | 1 | System-management interrupt output |

## Verification
On every cycle, the assertions check four things. The cascade line stays low. A fully masked or fully unrouted configuration leaves every output low on the next cycle. The configuration holds when there is no write. Read data holds when there is no read. Only the bench scenarios can show that every code from 0 to 31 sends each of the 62 sources to the correct line, including the redirection of code 2 to line 0. The same is true of OR-merging several sources and of the exact one-cycle output latency. Finally, the bench shows that writes to status addresses leave the configuration untouched.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  // Width of one source's lane inside a routing word.
  localparam int LANE_W = 8;
  // Legacy line reserved for the controller cascade.
  localparam int CASCADE_LINE = 2;
  // Line that receives code CASCADE_LINE instead of the cascade.
  localparam int CASCADE_ALT = 0;
endpackage

// File: rtl/irqm_cfg_regs.sv
module irqm_cfg_regs #(
  parameter int N_SRC  = 62,
  parameter int CODE_W = 5,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [N_SRC-1:0][CODE_W-1:0]   route_q,
  output logic [N_SRC-1:0]               mask_q
);
  import irqm_pkg::*;

  localparam int PER_WORD   = DATA_W / LANE_W;
  localparam int N_RT_WORDS = (N_SRC + PER_WORD - 1) / PER_WORD;
  localparam int N_ST_WORDS = (N_SRC + DATA_W - 1) / DATA_W;
  localparam int MASK_BASE  = N_RT_WORDS;

  logic [N_RT_WORDS-1:0]          rt_we;
  logic [N_ST_WORDS-1:0]          mk_we;
  logic [N_SRC-1:0][CODE_W-1:0]   route_d;
  logic [N_SRC-1:0]               mask_d;

  // Write enable decode per word
  generate
    for (genvar w = 0; w < N_RT_WORDS; w++) begin : g_rt_we
      assign rt_we[w] = wr_en && (addr == ADDR_W'(w));
    end
    for (genvar w = 0; w < N_ST_WORDS; w++) begin : g_mk_we
      assign mk_we[w] = wr_en && (addr == ADDR_W'(MASK_BASE + w));
    end
  endgenerate

  // Next-state per source
  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      always_comb begin
        route_d[s] = route_q[s];
        if (rt_we[s / PER_WORD])
          route_d[s] = wdata[LANE_W*(s % PER_WORD) +: CODE_W];
      end
      always_comb begin
        mask_d[s] = mask_q[s];
        if (mk_we[s / DATA_W])
          mask_d[s] = wdata[s % DATA_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      mask_q  <= '1;
    end else if (wr_en) begin
      route_q <= route_d;
      mask_q  <= mask_d;
    end
  end

  // R2 / R5 / R9: configuration only moves on a write strobe
  p_cfg_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(route_q) && $stable(mask_q)));

endmodule

// File: rtl/irqm_route_core.sv
module irqm_route_core #(
  parameter int N_SRC  = 62,
  parameter int N_LINE = 16,
  parameter int CODE_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SRC-1:0]               src_i,
  input  logic [N_SRC-1:0][CODE_W-1:0]   route_q,
  input  logic [N_SRC-1:0]               mask_q,
  output logic [N_LINE-1:0]              line_q,
  output logic                           mgmt_q
);
  import irqm_pkg::*;

  localparam int N_DEST = N_LINE + 1;   // legacy lines plus management
  localparam int MGMT_IDX = N_LINE;

  logic [N_SRC-1:0][N_DEST-1:0] dest_oh;
  logic [N_SRC-1:0]             live;
  logic [N_DEST-1:0]            dest_d;

  assign live = src_i & ~mask_q;

  // Per-source decode of the routing code to a one-hot destination
  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_dec
      always_comb begin
        dest_oh[s] = '0;
        if (route_q[s] == CODE_W'(MGMT_IDX)) begin
          dest_oh[s][MGMT_IDX] = 1'b1;
        end else if (route_q[s] == CODE_W'(CASCADE_LINE)) begin
          dest_oh[s][CASCADE_ALT] = 1'b1;
        end else if (route_q[s] != '0 && route_q[s] < CODE_W'(N_LINE)) begin
          dest_oh[s][route_q[s]] = 1'b1;
        end
      end
    end
  endgenerate

  // OR per destination over all live sources
  always_comb begin
    dest_d = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (live[s]) dest_d = dest_d | dest_oh[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      mgmt_q <= 1'b0;
    end else begin
      line_q <= dest_d[N_LINE-1:0];
      mgmt_q <= dest_d[MGMT_IDX];
    end
  end

  // R3: the cascade line is never driven
  p_cascade_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    line_q[CASCADE_LINE] == 1'b0);

  // R5: with every source masked, every output is low next cycle
  p_all_masked_quiet_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> (line_q == '0 && !mgmt_q));

  // R4: with every source unrouted, every output is low next cycle
  p_unrouted_quiet_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |=> (line_q == '0 && !mgmt_q));

endmodule

// File: rtl/irqm_rd_mux.sv
module irqm_rd_mux #(
  parameter int N_SRC  = 62,
  parameter int CODE_W = 5,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [N_SRC-1:0]               src_i,
  input  logic [N_SRC-1:0][CODE_W-1:0]   route_q,
  input  logic [N_SRC-1:0]               mask_q,
  output logic [DATA_W-1:0]              rdata_q
);
  import irqm_pkg::*;

  localparam int PER_WORD   = DATA_W / LANE_W;
  localparam int N_RT_WORDS = (N_SRC + PER_WORD - 1) / PER_WORD;
  localparam int N_ST_WORDS = (N_SRC + DATA_W - 1) / DATA_W;
  localparam int MASK_BASE  = N_RT_WORDS;
  localparam int RAW_BASE   = MASK_BASE + N_ST_WORDS;
  localparam int PEND_BASE  = RAW_BASE + N_ST_WORDS;
  localparam int PAD_W      = N_ST_WORDS * DATA_W;

  logic [N_RT_WORDS-1:0][DATA_W-1:0] rt_word;
  logic [PAD_W-1:0] mask_pad, raw_pad, pend_pad;
  logic [DATA_W-1:0] rdata_d;

  // Routing words: one byte lane per source, unused bits zero
  generate
    for (genvar w = 0; w < N_RT_WORDS; w++) begin : g_rtw
      for (genvar j = 0; j < PER_WORD; j++) begin : g_lane
        if (w * PER_WORD + j < N_SRC) begin : g_used
          assign rt_word[w][LANE_W*j +: LANE_W] =
            LANE_W'(route_q[w * PER_WORD + j]);
        end else begin : g_empty
          assign rt_word[w][LANE_W*j +: LANE_W] = '0;
        end
      end
    end
  endgenerate

  always_comb begin
    mask_pad = '0;
    raw_pad  = '0;
    pend_pad = '0;
    mask_pad[N_SRC-1:0] = mask_q;
    raw_pad[N_SRC-1:0]  = src_i;
    pend_pad[N_SRC-1:0] = src_i & ~mask_q;
  end

  always_comb begin
    rdata_d = '0;
    for (int w = 0; w < N_RT_WORDS; w++) begin
      if (addr == ADDR_W'(w)) rdata_d = rt_word[w];
    end
    for (int w = 0; w < N_ST_WORDS; w++) begin
      if (addr == ADDR_W'(MASK_BASE + w)) rdata_d = mask_pad[DATA_W*w +: DATA_W];
      if (addr == ADDR_W'(RAW_BASE + w))  rdata_d = raw_pad[DATA_W*w +: DATA_W];
      if (addr == ADDR_W'(PEND_BASE + w)) rdata_d = pend_pad[DATA_W*w +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  // R8: read data holds while no read is requested
  p_rdata_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));

endmodule

// File: rtl/irq_route_mapper.sv
module irq_route_mapper #(
  parameter int N_SRC  = 62,
  parameter int N_LINE = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_LINE-1:0] irq_line_o,
  output logic              smi_o
);
  localparam int CODE_W = $clog2(N_LINE + 1);

  logic [N_SRC-1:0][CODE_W-1:0] route_q;
  logic [N_SRC-1:0]             mask_q;

  irqm_cfg_regs #(
    .N_SRC(N_SRC), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .route_q(route_q), .mask_q(mask_q)
  );

  irqm_route_core #(
    .N_SRC(N_SRC), .N_LINE(N_LINE), .CODE_W(CODE_W)
  ) i_core (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .route_q(route_q),
    .mask_q(mask_q), .line_q(irq_line_o), .mgmt_q(smi_o)
  );

  irqm_rd_mux #(
    .N_SRC(N_SRC), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd_i), .addr(reg_addr_i),
    .src_i(src_i), .route_q(route_q), .mask_q(mask_q), .rdata_q(reg_rdata_o)
  );

endmodule

// File: tb/test_irq_route_mapper.sv
module test_irq_route_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 62;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] line;
  logic        smi;

  int n_run = 0, n_fail = 0;
  logic [4:0]  rt_m [NS];
  logic [63:0] mask_m;

  irq_route_mapper i_irq_route_mapper (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_line_o(line), .smi_o(smi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic logic [31:0] rt_word(input int w);
    logic [31:0] v = '0;
    for (int j = 0; j < 4; j++)
      if (4*w + j < NS) v[8*j +: 8] = {3'b000, rt_m[4*w + j]};
    return v;
  endfunction

  task automatic set_route(input int s, input logic [4:0] c);
    rt_m[s] = c;
    bus_wr(6'(s / 4), rt_word(s / 4));
  endtask

  task automatic put_mask();
    bus_wr(6'h10, mask_m[31:0]);
    bus_wr(6'h11, mask_m[63:32]);
  endtask

  function automatic logic [15:0] exp_line(input logic [4:0] c);
    if (c >= 1 && c <= 15) return (c == 2) ? 16'h0001 : (16'h1 << c);
    return 16'h0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int s = 0; s < NS; s++) rt_m[s] = '0;
    mask_m = 64'h3FFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(line == '0 && smi == 1'b0, "R1 outputs", {47'b0, smi, line}, 64'h0);
    chk(rdata == '0, "R1 rdata", rdata, 0);
    for (int a = 0; a < 16; a++) begin
      bus_rd(6'(a), d); chk(d == '0, "R1 route", d, 0);
    end
    bus_rd(6'h10, d); chk(d == 32'hFFFF_FFFF, "R1 mask0", d, 32'hFFFF_FFFF);
    bus_rd(6'h11, d); chk(d == 32'h3FFF_FFFF, "R1 mask1", d, 32'h3FFF_FFFF);

    // R5: masked sources drive nothing
    for (int s = 0; s < NS; s++) rt_m[s] = 5'(1 + (s % 16));
    for (int w = 0; w < 16; w++) bus_wr(6'(w), rt_word(w));
    @(negedge clk); src = '1;
    @(negedge clk);
    chk(line == '0 && !smi, "R5 masked all", {47'b0, smi, line}, 0);

    // R2: routing readback and lane layout
    for (int w = 0; w < 16; w++) begin
      bus_rd(6'(w), d); chk(d == rt_word(w), "R2 readback", d, rt_word(w));
    end

    // R7: raw and pending views
    src = 62'h2AAA_5555_F0F0_1234;
    mask_m = 64'h0F0F_00FF_1111_8888 & 64'h3FFF_FFFF_FFFF_FFFF;
    put_mask();
    bus_rd(6'h12, d); chk(d == src[31:0], "R7 raw0", d, src[31:0]);
    bus_rd(6'h13, d); chk(d == {2'b00, src[61:32]}, "R7 raw1", d, {2'b00, src[61:32]});
    bus_rd(6'h14, d); chk(d == (src[31:0] & ~mask_m[31:0]), "R7 pend0", d,
                          src[31:0] & ~mask_m[31:0]);
    bus_rd(6'h15, d); chk(d == ({2'b00, src[61:32]} & ~mask_m[63:32]), "R7 pend1", d,
                          {2'b00, src[61:32]} & ~mask_m[63:32]);
    bus_rd(6'h10, d); chk(d == mask_m[31:0], "R5 mask rd", d, mask_m[31:0]);

    // R9: writes to status addresses ignored
    for (int a = 18; a < 22; a++) bus_wr(6'(a), 32'hFFFF_FFFF);
    bus_rd(6'h10, d); chk(d == mask_m[31:0], "R9 mask0 kept", d, mask_m[31:0]);
    bus_rd(6'h11, d); chk(d == mask_m[63:32], "R9 mask1 kept", d, mask_m[63:32]);
    bus_rd(6'h12, d); chk(d == src[31:0], "R9 raw kept", d, src[31:0]);
    bus_rd(6'h05, d); chk(d == rt_word(5), "R9 route kept", d, rt_word(5));

    // R8: unmapped address reads zero; rdata holds without read
    bus_rd(6'h30, d); chk(d == 0, "R8 unmapped", d, 0);
    bus_rd(6'h03, d);
    repeat (3) @(negedge clk);
    chk(rdata == rt_word(3), "R8 hold", rdata, rt_word(3));

    // Clear configuration
    src = '0;
    for (int s = 0; s < NS; s++) rt_m[s] = '0;
    for (int w = 0; w < 16; w++) bus_wr(6'(w), rt_word(w));
    mask_m = 64'h3FFF_FFFF_FFFF_FFFF;
    put_mask();

    // R3 / R4: every source with every code
    for (int s = 0; s < NS; s++) begin
      mask_m[s] = 1'b0; put_mask();
      for (int c = 0; c < 32; c++) begin
        set_route(s, 5'(c));
        @(negedge clk); src = '0; src[s] = 1'b1;
        @(negedge clk);
        chk(line == exp_line(5'(c)) && smi == (c == 16),
            (c == 16 || c == 0 || c > 16) ? "R4 code sweep" : "R3 code sweep",
            {47'b0, smi, line}, {47'b0, (c == 16), exp_line(5'(c))});
        src = '0;
      end
      set_route(s, 5'd0);
      mask_m[s] = 1'b1; put_mask();
    end

    // R6: OR merge and one-cycle latency
    mask_m = 64'h3FFF_FFFF_FFFF_FFF0; put_mask();
    set_route(0, 5'd7); set_route(1, 5'd7); set_route(2, 5'd16); set_route(3, 5'd16);
    @(negedge clk); src = 62'h1;
    #1 chk(line == 16'h0, "R6 latency before edge", line, 0);
    @(negedge clk); chk(line == 16'h0080, "R6 single", line, 16'h0080);
    src = 62'h3;
    @(negedge clk); chk(line == 16'h0080, "R6 both", line, 16'h0080);
    src = 62'h2;
    @(negedge clk); chk(line == 16'h0080, "R6 other", line, 16'h0080);
    src = 62'hC;
    @(negedge clk); chk(line == 16'h0 && smi, "R6 mgmt or", {47'b0, smi, line}, 64'h10000);
    src = 62'h0;
    @(negedge clk); chk(line == 16'h0 && !smi, "R6 none", {47'b0, smi, line}, 0);
    // R5: masking one merged source keeps the other
    mask_m[0] = 1'b1; put_mask();
    src = 62'h3;
    @(negedge clk); chk(line == 16'h0080, "R5 partial mask", line, 16'h0080);
    mask_m[1] = 1'b1; put_mask();
    @(negedge clk); chk(line == 16'h0, "R5 both masked", line, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule